// File: doc/BRIEF.md
# Board Interrupt Aggregator and Control Register Bank

This block collects sixteen level-sensitive interrupt lines from board peripherals and folds them into one summary interrupt for the host processor. Each input is synchronised and compared with its value from the previous cycle. A changed input always updates an internal record of raw levels. If its enable bit is set, the change also overwrites a set/clear register with a one-hot code naming that input, and the summary output takes that input's new level. When several enabled inputs change in the same cycle, the lowest-numbered one is taken. A write to the enable register folds the set/clear register into the raw record. The pins that flip are reported on a per-pin status bus.

The same block also holds the board's plain control registers: two LED data words, an LED control word, a switch word, three miscellaneous control words, a miscellaneous status word and two card-slot words. They sit behind a single-cycle register port that covers a 1 MiB window. The port has no handshake and no back-pressure. A write commits on the clock edge where the write strobe is high, and read data is a combinational function of the address.

Top module: `brd_irq_bank`

## Requirements
- R1: After reset every mapped register reads zero, `irq_out` is 0 and `pin_lvl` and `pin_upd` are all zero.
- R2: The ten plain registers store and return all 32 bits at these offsets: 0x10 and 0x14 (LED data), 0x40 (LED control), 0x60 (switch), 0x80, 0x84 and 0x88 (control words), 0x90 (status word), 0xE0 and 0xE4 (card slots).
- R3: A read from any other offset returns zero, and a write to one changes no register.
- R4: The enable register (offset 0xC0) and the set/clear register (offset 0xD0) keep only the written bits selected by 0x000FEEFF. All other bits read back as zero.
- R5: When input n changes and enable bit n is 1, the set/clear register becomes 1<<n and `irq_out` takes the new level of input n. With the default two synchroniser stages, both are visible after the third rising edge that follows the input change.
- R6: A change on an input whose enable bit is 0 leaves `irq_out` and the set/clear register unchanged.
- R7: When several enabled inputs change in the same cycle, the one with the lowest index is latched, and `irq_out` follows that input's level.
- R8: A write to the enable register computes the level vector L = raw XOR setclr[15:0]. On the following edge, each `pin_lvl` bit set in setclr[15:0] takes L, the other bits hold, and `pin_upd` equals setclr[15:0] for exactly one cycle. L then becomes the raw record.
- R9: The raw record follows every input change, whether the input is enabled or not. This is observable through the `pin_lvl` result of a later enable write (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Asynchronous interrupt lines from the board |
| bus_addr | input | 20 | Byte offset inside the register window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Summary interrupt to the host |
| pin_lvl | output | 16 | Per-pin status driven by enable-register writes |
| pin_upd | output | 16 | One-cycle marker of the pins re-driven by the last enable write |

## Verification
The checker assumes that `bus_we` is the only way to alter the set/clear register other than a latched input event. It also assumes that an input change stays in place for at least the synchroniser depth, so that every change produces exactly one event. The stimulus holds each input vector for several cycles, and it never issues an enable write in the cycle where an input event commits. This keeps the two update paths of the raw record apart, so the bench model can apply them in a fixed order. Bus writes last one cycle each, with the address and data stable across the committing edge.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

  typedef enum logic [3:0] {
    SL_LED0   = 4'd0,
    SL_LED1   = 4'd1,
    SL_LEDCTL = 4'd2,
    SL_SWITCH = 4'd3,
    SL_CTL0   = 4'd4,
    SL_CTL1   = 4'd5,
    SL_CTL2   = 4'd6,
    SL_STAT   = 4'd7,
    SL_CARD0  = 4'd8,
    SL_CARD1  = 4'd9,
    SL_ENABLE = 4'd10,
    SL_LATCH  = 4'd11,
    SL_NONE   = 4'd15
  } slot_e;

  localparam int unsigned N_PLAIN = 10;

  // Map a window offset onto a register slot; anything else is unmapped.
  function automatic slot_e decode_off(input logic [31:0] off);
    case (off)
      32'h10:  decode_off = SL_LED0;
      32'h14:  decode_off = SL_LED1;
      32'h40:  decode_off = SL_LEDCTL;
      32'h60:  decode_off = SL_SWITCH;
      32'h80:  decode_off = SL_CTL0;
      32'h84:  decode_off = SL_CTL1;
      32'h88:  decode_off = SL_CTL2;
      32'h90:  decode_off = SL_STAT;
      32'hC0:  decode_off = SL_ENABLE;
      32'hD0:  decode_off = SL_LATCH;
      32'hE0:  decode_off = SL_CARD0;
      32'hE4:  decode_off = SL_CARD1;
      default: decode_off = SL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
  parameter int unsigned N      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= din;
      else stg[s] <= stg[(s == 0) ? 0 : s - 1];
    end
  end

  assign lvl = stg[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= lvl;
  end

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/brd_irq_pick.sv
module brd_irq_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] lvl,
  output logic         valid,
  output logic [N-1:0] onehot,
  output logic         level
);
  // Isolate the lowest set request bit: lowest index has priority.
  assign onehot = req & (~req + N'(1));
  assign valid  = |req;
  assign level  = |(onehot & lvl);
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int unsigned    N     = 16,
  parameter int unsigned    DW    = 32,
  parameter logic [DW-1:0]  WMASK = 32'h000F_EEFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mask,
  input  logic          wr_sc,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  chg,
  input  logic [N-1:0]  lvl,
  input  logic          evt_valid,
  input  logic [N-1:0]  evt_onehot,
  input  logic          evt_level,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] sc_q,
  output logic          irq_out,
  output logic [N-1:0]  pin_lvl,
  output logic [N-1:0]  pin_upd
);
  logic [N-1:0] raw_q;
  logic [N-1:0] sc_lo;
  logic [N-1:0] flip_lvl;
  logic [N-1:0] raw_base;
  logic [N-1:0] raw_next;

  assign sc_lo    = sc_q[N-1:0];
  assign flip_lvl = raw_q ^ sc_lo;

  always_comb begin
    raw_base = wr_mask ? flip_lvl : raw_q;
    raw_next = (raw_base & ~chg) | (lvl & chg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '0;
      sc_q    <= '0;
      irq_out <= 1'b0;
      pin_lvl <= '0;
      pin_upd <= '0;
    end else begin
      raw_q   <= raw_next;
      pin_upd <= '0;
      if (wr_mask) begin
        mask_q  <= wdata & WMASK;
        pin_lvl <= (pin_lvl & ~sc_lo) | (flip_lvl & sc_lo);
        pin_upd <= sc_lo;
      end
      if (wr_sc) sc_q <= wdata & WMASK;
      // An input event outranks a set/clear write in the same cycle.
      if (evt_valid) begin
        sc_q    <= {{(DW-N){1'b0}}, evt_onehot};
        irq_out <= evt_level;
      end
    end
  end
endmodule

// File: rtl/brd_reg_bank.sv
module brd_reg_bank #(
  parameter int unsigned NREG = 10,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   q [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) q[g] <= '0;
      else if (we[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/brd_irq_bank.sv
module brd_irq_bank #(
  parameter int unsigned   N_IRQ  = 16,
  parameter int unsigned   ADDR_W = 20,
  parameter int unsigned   DATA_W = 32,
  parameter int unsigned   SYNC_N = 2,
  parameter logic [31:0]   WMASK  = 32'h000F_EEFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic [N_IRQ-1:0]  pin_lvl,
  output logic [N_IRQ-1:0]  pin_upd
);
  import brd_irq_pkg::*;

  localparam int unsigned NP = N_PLAIN;

  slot_e             slot;
  logic [NP-1:0]     plain_we;
  logic [DATA_W-1:0] bank_q [NP];
  logic              wr_mask;
  logic              wr_sc;
  logic [N_IRQ-1:0]  sync_lvl;
  logic [N_IRQ-1:0]  sync_chg;
  logic [N_IRQ-1:0]  evt_onehot;
  logic              evt_valid;
  logic              evt_level;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] sc_q;

  assign slot    = decode_off({{(32-ADDR_W){1'b0}}, bus_addr});
  assign wr_mask = bus_we && (slot == SL_ENABLE);
  assign wr_sc   = bus_we && (slot == SL_LATCH);

  for (genvar i = 0; i < NP; i++) begin : g_we
    assign plain_we[i] = bus_we && (slot == slot_e'(i));
  end

  brd_reg_bank #(.NREG(NP), .DW(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (plain_we),
    .wdata (bus_wdata),
    .q     (bank_q)
  );

  brd_irq_sync #(.N(N_IRQ), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (irq_in),
    .lvl   (sync_lvl),
    .chg   (sync_chg)
  );

  brd_irq_pick #(.N(N_IRQ)) u_pick (
    .req    (sync_chg & mask_q[N_IRQ-1:0]),
    .lvl    (sync_lvl),
    .valid  (evt_valid),
    .onehot (evt_onehot),
    .level  (evt_level)
  );

  brd_irq_core #(.N(N_IRQ), .DW(DATA_W), .WMASK(WMASK[DATA_W-1:0])) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mask    (wr_mask),
    .wr_sc      (wr_sc),
    .wdata      (bus_wdata),
    .chg        (sync_chg),
    .lvl        (sync_lvl),
    .evt_valid  (evt_valid),
    .evt_onehot (evt_onehot),
    .evt_level  (evt_level),
    .mask_q     (mask_q),
    .sc_q       (sc_q),
    .irq_out    (irq_out),
    .pin_lvl    (pin_lvl),
    .pin_upd    (pin_upd)
  );

  always_comb begin
    bus_rdata = '0;
    case (slot)
      SL_ENABLE: bus_rdata = mask_q;
      SL_LATCH:  bus_rdata = sc_q;
      SL_NONE:   bus_rdata = '0;
      default: begin
        for (int i = 0; i < int'(NP); i++)
          if (slot == slot_e'(i)) bus_rdata = bank_q[i];
      end
    endcase
  end
endmodule

// File: rtl/brd_irq_bank_chk.sv
module brd_irq_bank_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          wr_mask,
  input logic          evt_valid,
  input logic          evt_level,
  input logic [DW-1:0] sc_q,
  input logic          irq_out,
  input logic [N-1:0]  pin_lvl,
  input logic [N-1:0]  pin_upd
);
  AST_LATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> ($countones(sc_q) == 1)); // R5

  AST_IRQ_TRACKS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (irq_out == $past(evt_level))); // R5

  AST_QUIET_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !bus_we) |=> ($stable(irq_out) && $stable(sc_q))); // R6

  AST_PULSE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_upd != '0) |-> $past(wr_mask)); // R8

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(pin_lvl)); // R8
endmodule

bind brd_irq_bank brd_irq_bank_chk #(.N(N_IRQ), .DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .wr_mask   (wr_mask),
  .evt_valid (evt_valid),
  .evt_level (evt_level),
  .sc_q      (sc_q),
  .irq_out   (irq_out),
  .pin_lvl   (pin_lvl),
  .pin_upd   (pin_upd)
);

// File: tb/brd_irq_bank_bench.sv
`timescale 1ns/1ps
module brd_irq_bank_bench;
  localparam logic [31:0] WM    = 32'h000F_EEFF;
  localparam logic [19:0] A_ENA = 20'hC0;
  localparam logic [19:0] A_LAT = 20'hD0;
  localparam int K_RD = 0, K_IRQ = 1, K_PINL = 2, K_PINU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [19:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [15:0] pin_lvl;
  logic [15:0] pin_upd;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // Reference model state, built from the requirements only
  logic [15:0] in_m = '0, raw_m = '0, pinl_m = '0;
  logic [31:0] ena_m = '0, lat_m = '0;
  logic        irq_m = 1'b0;

  logic [19:0] plain_off [10] = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80,
                                  20'h84, 20'h88, 20'h90, 20'hE0, 20'hE4};

  brd_irq_bank u_brd_irq_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .pin_lvl(pin_lvl), .pin_upd(pin_upd)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.due = cyc; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares due items away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_IRQ:   act = {31'b0, irq_out};
        K_PINL:  act = {16'b0, pin_lvl};
        default: act = {16'b0, pin_upd};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk_rd(logic [19:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    bus_addr = a;
    push(K_RD, exp, tag);
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d, string tag);
    logic [15:0] sc, lv;
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    if (a == A_ENA) begin
      sc = lat_m[15:0];
      lv = raw_m ^ sc;
      pinl_m = (pinl_m & ~sc) | (lv & sc);
      raw_m = lv;
      ena_m = d & WM;
      push(K_PINU, {16'b0, sc}, tag);
      push(K_PINL, {16'b0, pinl_m}, tag);
      @(posedge clk); #1;
      push(K_PINU, 32'h0, tag);
    end else if (a == A_LAT) begin
      lat_m = d & WM;
    end
  endtask

  task automatic drive_in(logic [15:0] v, string tag);
    logic [15:0] ch, en;
    ch = v ^ in_m;
    en = ch & ena_m[15:0];
    raw_m = (raw_m & ~ch) | (v & ch);
    if (en != 0) begin
      for (int k = 15; k >= 0; k--)
        if (en[k]) begin lat_m = 32'(1) << k; irq_m = v[k]; end
    end
    in_m = v;
    @(posedge clk); #1;
    irq_in = v;
    repeat (3) @(posedge clk);
    #1;
    push(K_IRQ, {31'b0, irq_m}, tag);
    chk_rd(A_LAT, lat_m, tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    push(K_IRQ, 32'h0, "R1");
    push(K_PINL, 32'h0, "R1");
    push(K_PINU, 32'h0, "R1");
    for (int i = 0; i < 10; i++) chk_rd(plain_off[i], 32'h0, "R1");
    chk_rd(A_ENA, 32'h0, "R1");
    chk_rd(A_LAT, 32'h0, "R1");

    // R2: plain registers keep all 32 bits
    for (int i = 0; i < 10; i++) wr(plain_off[i], 32'hA5C3_0000 ^ (32'(i) * 32'h0101_1357), "R2");
    for (int i = 0; i < 10; i++) chk_rd(plain_off[i], 32'hA5C3_0000 ^ (32'(i) * 32'h0101_1357), "R2");

    // R3: unmapped offsets
    wr(20'h44, 32'hDEAD_BEEF, "R3");
    wr(20'h00, 32'h1234_5678, "R3");
    wr(20'hC4, 32'hFFFF_FFFF, "R3");
    chk_rd(20'h44, 32'h0, "R3");
    chk_rd(20'hC4, 32'h0, "R3");
    chk_rd(20'h4_0010, 32'h0, "R3");
    for (int i = 0; i < 10; i++) chk_rd(plain_off[i], 32'hA5C3_0000 ^ (32'(i) * 32'h0101_1357), "R3");
    chk_rd(A_ENA, 32'h0, "R3");

    // R4: write filter on enable and set/clear
    wr(A_ENA, 32'hFFFF_FFFF, "R4");
    chk_rd(A_ENA, 32'h000F_EEFF, "R4");
    wr(A_LAT, 32'hFFFF_FFFF, "R4");
    chk_rd(A_LAT, 32'h000F_EEFF, "R4");
    wr(A_LAT, 32'h0, "R4");
    wr(A_ENA, 32'h0, "R4");
    chk_rd(A_ENA, 32'h0, "R4");

    // R6 and R9: disabled input still moves the raw record
    drive_in(16'h0040, "R6");
    wr(A_LAT, 32'h0000_0042, "R9");
    wr(A_ENA, 32'h0000_0000, "R9");

    // R5: enabled input, rise then fall
    wr(A_LAT, 32'h0, "R5");
    wr(A_ENA, 32'h0000_00FF, "R5");
    drive_in(16'h0048, "R5");
    drive_in(16'h0040, "R5");

    // R7: simultaneous enabled changes, lowest wins
    drive_in(16'h00C4, "R7");
    drive_in(16'h0044, "R7");

    // R6: disabled bit 9 toggles, nothing moves
    drive_in(16'h0244, "R6");
    drive_in(16'h0044, "R6");

    // R7: enabled bit 0 with disabled bit 10 at once
    drive_in(16'h0445, "R7");

    // R8: recompute with a multi-bit set/clear value
    wr(A_LAT, 32'h000F_0305, "R8");
    wr(A_ENA, 32'h0000_00FF, "R8");
    chk_rd(A_ENA, 32'h0000_00FF, "R8");

    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule